// File: doc/BRIEF.md
# Pulse-Verify Programming Sequencer

This block writes a range of bytes into a one-time-programmable memory whose cells need program pulses. For every address it drives the address and the byte from a data-source port, waits out a setup window, fires one active-low program pulse of fixed width, releases the data bus and reads the cell back with the output enable low. A byte that reads back correctly moves the cursor to the next address. A byte that does not match is pulsed again. After a bounded number of pulses without a match, the run stops and reports failure.

After the last address has been programmed, the whole range is read back twice. The first pass runs at a raised supply level and the second at a lowered one. Any mismatch reports failure, and a run with no mismatch reports success.

A host starts a run with a one-cycle start pulse and watches `done_o` and `fail_o`. On failure, the offending address is latched for the host. All analog timing (setup, pulse width, data hold, read access and output float) is set by parameters counted in clock cycles. The supply request is a two-bit code that an external regulator acts on.

Top module: `prog_seq_top`

## Requirements
- R1: While reset is held and after it is released, `mem_ce_n_o`=1, `mem_oe_n_o`=1, `mem_dq_oe_o`=0, `done_o`=0, `fail_o`=0 and `supply_o`=0 (nominal read level).
- R2: During programming, `supply_o`=1 (programming level). Pulses start at address 0, and the address stays the same or rises by exactly one from one pulse to the next. During each pulse, `mem_dq_o` carries the source byte for `mem_addr_o`.
- R3: Each program pulse holds `mem_ce_n_o` low for exactly PULSE_CYC cycles, with `mem_oe_n_o` high and the data driven. Address, data and high output enable are in place for at least SETUP_CYC cycles before the falling edge. The data stays driven for at least HOLD_CYC cycles after the rising edge.
- R4: After every pulse, the cell is read with `mem_oe_n_o` low. A match advances to the next address with the retry count cleared, so a cell that needs k pulses (k ≤ MAX_PULSES) costs exactly k pulses.
- R5: If a cell still mismatches after its MAX_PULSES-th pulse, the run ends with `done_o`=1 and `fail_o`=1, `fail_addr_o` holds that address, and no further pulse is issued.
- R6: After the last address, every byte is read with `mem_ce_n_o` and `mem_oe_n_o` low. The first full pass uses `supply_o`=2 (raised check level), and only after it completes does a second pass use `supply_o`=3 (lowered check level).
- R7: A mismatch in either check pass ends the run at once with `done_o`=1, `fail_o`=1 and `fail_addr_o` set to that address. Two clean passes end with `done_o`=1 and `fail_o`=0, and the memory then holds the source data.
- R8: `mem_dq_oe_o` is never 1 while `mem_oe_n_o` is 0.
- R9: `done_o`, `fail_o` and `fail_addr_o` hold until the next `start_i`. A start while a run is in progress has no effect. A start after a finished run clears `done_o` and `fail_o` on the next cycle and begins a new run.
- R10: Whenever `done_o` is 1, `supply_o` is back to 0, and `mem_ce_n_o` is never low at supply code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | One-cycle request to begin a run |
| done_o | output | 1 | Run finished; held until next start |
| fail_o | output | 1 | Run finished with a failure |
| fail_addr_o | output | AW | Address that caused the failure |
| src_addr_o | output | AW | Address presented to the data source |
| src_data_i | input | DW | Byte from the data source for `src_addr_o` |
| mem_addr_o | output | AW | Memory address |
| mem_dq_o | output | DW | Data to be programmed |
| mem_dq_oe_o | output | 1 | Drive enable for `mem_dq_o` onto the bus |
| mem_dq_i | input | DW | Data read back from the memory |
| mem_ce_n_o | output | 1 | Active-low chip enable / program pulse |
| mem_oe_n_o | output | 1 | Active-low output enable |
| supply_o | output | 2 | Supply request: 0 nominal, 1 programming, 2 raised check, 3 lowered check |

## Verification
The closest collision is at the final address. The verify result that exhausts the retry budget arrives in the same decision cycle that would otherwise leave programming for the check passes. The bench makes the last cell refuse to program and expects exactly MAX_PULSES pulses on it, a failure naming that address, and no read at either check level. A second collision is a start request that overlaps a run in progress. The bench pulses start several times mid-run and requires the pulse count and both pass read counts to match a single uninterrupted run.

// File: rtl/prog_seq_pkg.sv
package prog_seq_pkg;

    typedef enum logic [1:0] {
        SUP_NOM    = 2'd0,
        SUP_PROG   = 2'd1,
        SUP_CHK_HI = 2'd2,
        SUP_CHK_LO = 2'd3
    } supply_e;

    typedef enum logic [3:0] {
        PH_IDLE,
        PH_PSETUP,
        PH_PULSE,
        PH_PHOLD,
        PH_TURN,
        PH_VREAD,
        PH_VFLOAT,
        PH_CSETUP,
        PH_CREAD,
        PH_CFLOAT,
        PH_END
    } phase_e;

    function automatic int max_of(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/prog_seq_timer.sv
module prog_seq_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] val_i,
    output logic         zero_o
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i)
            cnt_d = val_i;
        else if (cnt_q != '0)
            cnt_d = cnt_q - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/prog_seq_cursor.sv
module prog_seq_cursor #(
    parameter int AW         = 19,
    parameter int LAST_ADDR  = 524287,
    parameter int MAX_PULSES = 10,
    parameter int RW         = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          restart_i,
    input  logic          rewind_i,
    input  logic          addr_next_i,
    input  logic          retry_inc_i,
    output logic [AW-1:0] addr_o,
    output logic          at_last_o,
    output logic          at_limit_o
);
    typedef struct packed {
        logic [AW-1:0] addr;
        logic [RW-1:0] retry;
    } cur_t;

    cur_t cur_d, cur_q;

    always_comb begin
        cur_d = cur_q;
        if (restart_i || rewind_i) begin
            cur_d.addr  = '0;
            cur_d.retry = '0;
        end else if (addr_next_i) begin
            cur_d.addr  = cur_q.addr + 1'b1;
            cur_d.retry = '0;
        end else if (retry_inc_i) begin
            cur_d.retry = cur_q.retry + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cur_q <= '0;
        else        cur_q <= cur_d;
    end

    assign addr_o     = cur_q.addr;
    assign at_last_o  = (cur_q.addr == AW'(LAST_ADDR));
    assign at_limit_o = (cur_q.retry == RW'(MAX_PULSES - 1));
endmodule

// File: rtl/prog_seq_cmp.sv
module prog_seq_cmp #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear_i,
    input  logic          sample_i,
    input  logic [DW-1:0] exp_i,
    input  logic [DW-1:0] obs_i,
    output logic          match_o
);
    logic match_d, match_q;

    always_comb begin
        match_d = match_q;
        if (clear_i)
            match_d = 1'b0;
        else if (sample_i)
            match_d = (obs_i == exp_i);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) match_q <= 1'b0;
        else        match_q <= match_d;
    end

    assign match_o = match_q;
endmodule

// File: rtl/prog_seq_top.sv
module prog_seq_top
    import prog_seq_pkg::*;
#(
    parameter int AW         = 19,
    parameter int DW         = 8,
    parameter int NUM_BYTES  = 524288,
    parameter int SETUP_CYC  = 250,
    parameter int PULSE_CYC  = 12500,
    parameter int HOLD_CYC   = 250,
    parameter int READ_CYC   = 25,
    parameter int FLOAT_CYC  = 15,
    parameter int MAX_PULSES = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    output logic          done_o,
    output logic          fail_o,
    output logic [AW-1:0] fail_addr_o,
    output logic [AW-1:0] src_addr_o,
    input  logic [DW-1:0] src_data_i,
    output logic [AW-1:0] mem_addr_o,
    output logic [DW-1:0] mem_dq_o,
    output logic          mem_dq_oe_o,
    input  logic [DW-1:0] mem_dq_i,
    output logic          mem_ce_n_o,
    output logic          mem_oe_n_o,
    output logic [1:0]    supply_o
);
    localparam int LAST_ADDR = NUM_BYTES - 1;
    localparam int RW        = $clog2(MAX_PULSES + 1);
    localparam int TMAX      = max_of(max_of(SETUP_CYC, PULSE_CYC),
                                      max_of(max_of(HOLD_CYC, READ_CYC), FLOAT_CYC));
    localparam int TW        = $clog2(TMAX + 1);

    localparam logic [TW-1:0] T_SETUP = TW'(SETUP_CYC - 1);
    localparam logic [TW-1:0] T_PULSE = TW'(PULSE_CYC - 1);
    localparam logic [TW-1:0] T_HOLD  = TW'(HOLD_CYC - 1);
    localparam logic [TW-1:0] T_READ  = TW'(READ_CYC - 1);
    localparam logic [TW-1:0] T_FLOAT = TW'(FLOAT_CYC - 1);

    typedef struct packed {
        phase_e        ph;
        logic          pass_lo;
        logic          done;
        logic          fail;
        logic [AW-1:0] fail_addr;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic          t_load, t_zero;
    logic [TW-1:0] t_val;
    logic          cur_restart, cur_rewind, cur_next, cur_retry;
    logic [AW-1:0] cur_addr;
    logic          cur_last, cur_limit;
    logic          cmp_clear, cmp_sample, cmp_match;
    supply_e       sup;

    prog_seq_timer #(.W(TW)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .load_i (t_load),
        .val_i  (t_val),
        .zero_o (t_zero)
    );

    prog_seq_cursor #(
        .AW         (AW),
        .LAST_ADDR  (LAST_ADDR),
        .MAX_PULSES (MAX_PULSES),
        .RW         (RW)
    ) u_cursor (
        .clk         (clk),
        .rst_n       (rst_n),
        .restart_i   (cur_restart),
        .rewind_i    (cur_rewind),
        .addr_next_i (cur_next),
        .retry_inc_i (cur_retry),
        .addr_o      (cur_addr),
        .at_last_o   (cur_last),
        .at_limit_o  (cur_limit)
    );

    prog_seq_cmp #(.DW(DW)) u_cmp (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear_i  (cmp_clear),
        .sample_i (cmp_sample),
        .exp_i    (src_data_i),
        .obs_i    (mem_dq_i),
        .match_o  (cmp_match)
    );

    // next-state logic
    always_comb begin
        ctl_d       = ctl_q;
        cur_restart = 1'b0;
        cur_rewind  = 1'b0;
        cur_next    = 1'b0;
        cur_retry   = 1'b0;
        cmp_clear   = 1'b0;
        cmp_sample  = 1'b0;

        unique case (ctl_q.ph)
            PH_IDLE, PH_END: begin
                if (start_i) begin
                    ctl_d.ph        = PH_PSETUP;
                    ctl_d.pass_lo   = 1'b0;
                    ctl_d.done      = 1'b0;
                    ctl_d.fail      = 1'b0;
                    ctl_d.fail_addr = '0;
                    cur_restart     = 1'b1;
                    cmp_clear       = 1'b1;
                end
            end
            PH_PSETUP: if (t_zero) ctl_d.ph = PH_PULSE;
            PH_PULSE:  if (t_zero) ctl_d.ph = PH_PHOLD;
            PH_PHOLD:  if (t_zero) ctl_d.ph = PH_TURN;
            PH_TURN:   if (t_zero) ctl_d.ph = PH_VREAD;
            PH_VREAD: begin
                if (t_zero) begin
                    cmp_sample = 1'b1;
                    ctl_d.ph   = PH_VFLOAT;
                end
            end
            PH_VFLOAT: begin
                if (t_zero) begin
                    if (cmp_match) begin
                        if (cur_last) begin
                            ctl_d.ph      = PH_CSETUP;
                            ctl_d.pass_lo = 1'b0;
                            cur_rewind    = 1'b1;
                        end else begin
                            ctl_d.ph = PH_PSETUP;
                            cur_next = 1'b1;
                        end
                    end else if (cur_limit) begin
                        ctl_d.ph        = PH_END;
                        ctl_d.done      = 1'b1;
                        ctl_d.fail      = 1'b1;
                        ctl_d.fail_addr = cur_addr;
                    end else begin
                        ctl_d.ph  = PH_PSETUP;
                        cur_retry = 1'b1;
                    end
                end
            end
            PH_CSETUP: if (t_zero) ctl_d.ph = PH_CREAD;
            PH_CREAD: begin
                if (t_zero) begin
                    cmp_sample = 1'b1;
                    ctl_d.ph   = PH_CFLOAT;
                end
            end
            PH_CFLOAT: begin
                if (t_zero) begin
                    if (!cmp_match) begin
                        ctl_d.ph        = PH_END;
                        ctl_d.done      = 1'b1;
                        ctl_d.fail      = 1'b1;
                        ctl_d.fail_addr = cur_addr;
                    end else if (!cur_last) begin
                        ctl_d.ph = PH_CREAD;
                        cur_next = 1'b1;
                    end else if (!ctl_q.pass_lo) begin
                        ctl_d.ph      = PH_CSETUP;
                        ctl_d.pass_lo = 1'b1;
                        cur_rewind    = 1'b1;
                    end else begin
                        ctl_d.ph   = PH_END;
                        ctl_d.done = 1'b1;
                    end
                end
            end
            default: ctl_d.ph = PH_IDLE;
        endcase
    end

    // phase timer reload on every phase change
    always_comb begin
        t_load = (ctl_d.ph != ctl_q.ph);
        unique case (ctl_d.ph)
            PH_PSETUP, PH_CSETUP: t_val = T_SETUP;
            PH_PULSE:             t_val = T_PULSE;
            PH_PHOLD:             t_val = T_HOLD;
            PH_VREAD, PH_CREAD:   t_val = T_READ;
            PH_VFLOAT, PH_CFLOAT: t_val = T_FLOAT;
            default:              t_val = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ctl_q <= '{ph: PH_IDLE, pass_lo: 1'b0, done: 1'b0, fail: 1'b0, fail_addr: '0};
        else
            ctl_q <= ctl_d;
    end

    // pin decode from the registered phase
    always_comb begin
        mem_ce_n_o  = 1'b1;
        mem_oe_n_o  = 1'b1;
        mem_dq_oe_o = 1'b0;
        sup         = SUP_NOM;
        unique case (ctl_q.ph)
            PH_PSETUP, PH_PHOLD: begin
                sup         = SUP_PROG;
                mem_dq_oe_o = 1'b1;
            end
            PH_PULSE: begin
                sup         = SUP_PROG;
                mem_dq_oe_o = 1'b1;
                mem_ce_n_o  = 1'b0;
            end
            PH_TURN, PH_VFLOAT: sup = SUP_PROG;
            PH_VREAD: begin
                sup        = SUP_PROG;
                mem_oe_n_o = 1'b0;
            end
            PH_CSETUP, PH_CFLOAT: sup = ctl_q.pass_lo ? SUP_CHK_LO : SUP_CHK_HI;
            PH_CREAD: begin
                sup        = ctl_q.pass_lo ? SUP_CHK_LO : SUP_CHK_HI;
                mem_ce_n_o = 1'b0;
                mem_oe_n_o = 1'b0;
            end
            default: sup = SUP_NOM;
        endcase
    end

    assign supply_o    = sup;
    assign mem_addr_o  = cur_addr;
    assign src_addr_o  = cur_addr;
    assign mem_dq_o    = src_data_i;
    assign done_o      = ctl_q.done;
    assign fail_o      = ctl_q.fail;
    assign fail_addr_o = ctl_q.fail_addr;
endmodule

// File: rtl/prog_seq_chk.sv
module prog_seq_chk #(
    parameter int AW = 19,
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start_i,
    input logic          done_o,
    input logic          fail_o,
    input logic [AW-1:0] fail_addr_o,
    input logic [AW-1:0] mem_addr_o,
    input logic [DW-1:0] mem_dq_o,
    input logic          mem_dq_oe_o,
    input logic          mem_ce_n_o,
    input logic          mem_oe_n_o,
    input logic [1:0]    supply_o
);
    // R8
    no_contention_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_dq_oe_o && !mem_oe_n_o));

    // R3
    pulse_drive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce_n_o && supply_o == 2'd1) |-> (mem_oe_n_o && mem_dq_oe_o));

    // R3
    pulse_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce_n_o && supply_o == 2'd1) |=> ($stable(mem_addr_o) && $stable(mem_dq_o)));

    // R9
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> (done_o && $stable(fail_o) && $stable(fail_addr_o)));

    // R9
    restart_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && start_i) |=> (!done_o && !fail_o));

    // R5
    fail_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fail_o |-> done_o);

    // R10
    idle_supply_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (supply_o == 2'd0 && mem_ce_n_o));

    // R6
    check_read_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!mem_ce_n_o && !mem_oe_n_o) |-> supply_o[1]);
endmodule

bind prog_seq_top prog_seq_chk #(.AW(AW), .DW(DW)) u_prog_seq_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .done_o      (done_o),
    .fail_o      (fail_o),
    .fail_addr_o (fail_addr_o),
    .mem_addr_o  (mem_addr_o),
    .mem_dq_o    (mem_dq_o),
    .mem_dq_oe_o (mem_dq_oe_o),
    .mem_ce_n_o  (mem_ce_n_o),
    .mem_oe_n_o  (mem_oe_n_o),
    .supply_o    (supply_o)
);

// File: tb/tb_prog_seq_top.sv
`timescale 1ns/1ps
module tb_prog_seq_top;
    localparam int AW = 3, DW = 8, NB = 8;
    localparam int SETUP = 3, PULSE = 5, HOLD = 2, READ = 2, FLOAT = 2, MAXP = 10;

    // need_addr, need_cnt, hi_bad, lo_bad, exp_fail, exp_faddr, exp_pulses, exp_hi, exp_lo
    localparam int NV = 9;
    localparam int VEC [NV][9] = '{
        '{-1,  1, -1, -1, 0, 0,  8, 8, 8},
        '{ 3,  4, -1, -1, 0, 0, 11, 8, 8},
        '{ 2, 10, -1, -1, 0, 0, 17, 8, 8},
        '{ 5, 11, -1, -1, 1, 5, 15, 0, 0},
        '{ 7, 99, -1, -1, 1, 7, 17, 0, 0},
        '{-1,  1,  4, -1, 1, 4,  8, 5, 0},
        '{-1,  1,  7, -1, 1, 7,  8, 8, 0},
        '{-1,  1, -1,  6, 1, 6,  8, 8, 7},
        '{-1,  1, -1,  0, 1, 0,  8, 8, 1}
    };

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
    logic done, fail;
    logic [AW-1:0] fail_addr, src_addr, mem_addr;
    logic [DW-1:0] src_data, mem_dq, mem_dq_in;
    logic dq_oe, ce_n, oe_n;
    logic [1:0] sup;

    always #2 clk = ~clk;

    prog_seq_top #(
        .AW(AW), .DW(DW), .NUM_BYTES(NB), .SETUP_CYC(SETUP), .PULSE_CYC(PULSE),
        .HOLD_CYC(HOLD), .READ_CYC(READ), .FLOAT_CYC(FLOAT), .MAX_PULSES(MAXP)
    ) dut (
        .clk(clk), .rst_n(rst_n), .start_i(start), .done_o(done), .fail_o(fail),
        .fail_addr_o(fail_addr), .src_addr_o(src_addr), .src_data_i(src_data),
        .mem_addr_o(mem_addr), .mem_dq_o(mem_dq), .mem_dq_oe_o(dq_oe),
        .mem_dq_i(mem_dq_in), .mem_ce_n_o(ce_n), .mem_oe_n_o(oe_n), .supply_o(sup)
    );

    function automatic logic [DW-1:0] src_fn(input int a);
        return DW'((a * 37 + 5) % 256);
    endfunction

    assign src_data = src_fn(int'(src_addr));

    int need_addr = -1, need_cnt = 1, hi_bad = -1, lo_bad = -1;
    logic mon_clr = 1'b1;
    logic [DW-1:0] mem [NB];
    int pulses_at [NB];
    int total_pulses, hi_reads, lo_reads, width_bad, setup_bad, hold_bad, data_bad;
    int order_bad, cont_bad, rd_order_bad, sup_bad, run_len, setup_cnt, hold_cnt, last_addr;
    int cyc = 0;
    logic in_hold, prev_ce, prev_oe;
    int total = 0, bad = 0;

    always_comb begin
        logic [DW-1:0] rd;
        rd = mem[mem_addr];
        if (sup == 2'd2 && int'(mem_addr) == hi_bad) rd = rd ^ 8'h01;
        if (sup == 2'd3 && int'(mem_addr) == lo_bad) rd = rd ^ 8'h01;
        mem_dq_in = oe_n ? 8'h00 : rd;
    end

    // memory model and pin monitors, all sampled at the falling edge
    always @(negedge clk) begin
        cyc++;
        if (mon_clr) begin
            for (int i = 0; i < NB; i++) begin mem[i] = 8'hFF; pulses_at[i] = 0; end
            total_pulses = 0; hi_reads = 0; lo_reads = 0; width_bad = 0; setup_bad = 0;
            hold_bad = 0; data_bad = 0; order_bad = 0; cont_bad = 0; rd_order_bad = 0;
            sup_bad = 0; run_len = 0; setup_cnt = 0; hold_cnt = 0; last_addr = -1;
            in_hold = 1'b0; prev_ce = 1'b1; prev_oe = 1'b1;
        end else begin
            if (dq_oe && !oe_n) cont_bad++;
            if (!ce_n && sup == 2'd0) sup_bad++;
            if (sup == 2'd1 && !ce_n) begin
                if (prev_ce) begin
                    int a;
                    a = int'(mem_addr);
                    total_pulses++;
                    if (setup_cnt < SETUP) setup_bad++;
                    if (mem_dq != src_fn(a)) data_bad++;
                    if (last_addr < 0 ? (a != 0) : (a != last_addr && a != last_addr + 1)) order_bad++;
                    last_addr = a;
                    pulses_at[a]++;
                    if (pulses_at[a] >= ((a == need_addr) ? need_cnt : 1)) mem[a] = mem[a] & mem_dq;
                    run_len = 0;
                end
                run_len++;
            end
            if (!prev_ce && ce_n && sup == 2'd1) begin
                if (run_len != PULSE) width_bad++;
                in_hold = 1'b1; hold_cnt = 0;
            end
            if (in_hold) begin
                if (dq_oe) hold_cnt++;
                else begin
                    if (hold_cnt < HOLD) hold_bad++;
                    in_hold = 1'b0;
                end
            end
            if (sup == 2'd1 && ce_n && oe_n && dq_oe) setup_cnt++; else setup_cnt = 0;
            if (!ce_n && !oe_n && prev_oe) begin
                if (sup == 2'd2) begin hi_reads++; if (lo_reads > 0) rd_order_bad++; end
                else if (sup == 2'd3) lo_reads++;
            end
            prev_ce = ce_n; prev_oe = oe_n;
        end
        if (cyc > 150000) begin
            $display("FAIL watchdog actual=%0d expected=0", cyc);
            $display("  test done: total=%0d bad=%0d", total + 1, bad + 1);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_done();
        bit seen = 0;
        for (int i = 0; i < 5000 && !seen; i++) begin
            @(negedge clk);
            if (done) seen = 1;
        end
        if (!seen) chk("R9 run timeout", 0, 1);
    endtask

    task automatic pulse_start();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic run_vec(input int v, input bit pokes);
        need_addr = VEC[v][0]; need_cnt = VEC[v][1]; hi_bad = VEC[v][2]; lo_bad = VEC[v][3];
        mon_clr = 1'b1; repeat (2) @(posedge clk); mon_clr = 1'b0;
        pulse_start();
        if (pokes) begin
            for (int k = 0; k < 3; k++) begin
                repeat (25) @(negedge clk);
                start = 1'b1; @(negedge clk); start = 1'b0;
            end
        end
        wait_done();
        chk("R9 done", int'(done), 1);
        chk("R5 R7 fail flag", int'(fail), VEC[v][4]);
        if (VEC[v][4] != 0) chk("R5 R7 fail_addr", int'(fail_addr), VEC[v][5]);
        chk("R4 R5 pulse count", total_pulses, VEC[v][6]);
        chk("R6 raised-level reads", hi_reads, VEC[v][7]);
        chk("R6 lowered-level reads", lo_reads, VEC[v][8]);
        chk("R6 pass order", rd_order_bad, 0);
        chk("R10 supply at end", int'(sup), 0);
        chk("R10 ce at nominal", sup_bad, 0);
        chk("R3 pulse width", width_bad, 0);
        chk("R3 setup", setup_bad, 0);
        chk("R3 hold", hold_bad, 0);
        chk("R2 data", data_bad, 0);
        chk("R2 address order", order_bad, 0);
        chk("R8 contention", cont_bad, 0);
        if (VEC[v][4] == 0) begin
            int mm = 0;
            for (int i = 0; i < NB; i++) if (mem[i] != src_fn(i)) mm++;
            chk("R7 memory contents", mm, 0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 ce_n", int'(ce_n), 1);
        chk("R1 oe_n", int'(oe_n), 1);
        chk("R1 dq_oe", int'(dq_oe), 0);
        chk("R1 done", int'(done), 0);
        chk("R1 fail", int'(fail), 0);
        chk("R1 supply", int'(sup), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 idle after release", int'(done) + int'(fail) + int'(!ce_n), 0);

        for (int v = 0; v < NV; v++) run_vec(v, 1'b0);

        // R5 failure at the last address beside the end-of-range step
        run_vec(4, 1'b0);
        // R9 result held until next start
        repeat (20) @(negedge clk);
        chk("R9 done held", int'(done), 1);
        chk("R9 fail held", int'(fail), 1);
        chk("R9 fail_addr held", int'(fail_addr), 7);
        // R9 restart clears the result on the next cycle
        need_addr = -1; need_cnt = 1; hi_bad = -1; lo_bad = -1;
        mon_clr = 1'b1; repeat (2) @(posedge clk); mon_clr = 1'b0;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        chk("R9 restart clears done", int'(done), 0);
        chk("R9 restart clears fail", int'(fail), 0);
        wait_done();
        chk("R9 restart run passes", int'(fail), 0);
        // R9 start while busy is ignored
        run_vec(0, 1'b1);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule